// File: doc/BRIEF.md
# Cluster-to-Global Bus Coherence Filter

This block sits between the local bus of one processor cluster and the global bus that joins all clusters, in a machine whose main memory is split across the clusters. Every line has a home cluster, and the top two address bits name it. The filter watches one transaction per cycle on each bus. For each one it decides whether the transaction must cross to the other bus, and it keeps its own record of where copies of lines live up to date. The aim is that only the traffic coherence needs leaves or enters the cluster.

Two tag stores hold that record. The first is a set-associative store of remote-home lines held inside this cluster, each marked shared or dirty. The second is a direct-mapped, tag-only directory of local-home lines that other clusters hold, each marked shared-remote or dirty-remote. A crossing decision is made from a single-cycle lookup of both stores. It appears as a registered strobe, with the address and command of the original transaction, one cycle after the snoop. Data, memory banks and the physical link are handled elsewhere.

Top module: `cf_cluster_filter`

## Requirements
- R1: After reset both forward strobes are low and both tag stores are empty, so no line counts as held anywhere.
- R2: A line is local-home when address bits [31:30] equal the MY_ID parameter, and remote-home otherwise.
- R3: A local write (loc_wr=1) is forwarded to the global bus when the line is remote-home, or when it is local-home and the directory marks it shared-remote or dirty-remote. After such a local write to a local-home line, the directory entry becomes invalid.
- R4: A local read (loc_wr=0) is forwarded to the global bus in two cases: the line is remote-home and misses in the remote-line store, or the line is local-home and the directory marks it dirty-remote. Such a read of a dirty-remote line downgrades the entry to shared-remote.
- R5: A global write from another cluster is forwarded to the local bus when the line is local-home, or when it is remote-home and held dirty in the remote-line store.
- R6: A global read is never forwarded to the local bus. A global transaction whose source field glb_src equals MY_ID is ignored entirely: it is not forwarded and changes no tag.
- R7: A forward strobe rises exactly one cycle after the snoop that caused it, and carries that snoop's address and command (1 = write, 0 = read).
- R8: A local read of a remote-home line that misses installs it as shared, and a local write installs it or marks it dirty. The store is 4-way set associative over address bits [8:5]. The lowest-numbered invalid way is filled first. When a set is full, a per-set round-robin pointer that starts at way 0 picks the victim and then advances.
- R9: A global write from another cluster to a remote-home line invalidates this cluster's copy of that line in the remote-line store.
- R10: A global read from another cluster to a local-home line sets its directory entry to shared-remote. A global write sets it to dirty-remote.
- R11: When both buses carry a transaction in the same cycle, the global transaction's tag update is applied first, and the local decision sees its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_vld | input | 1 | Local bus transaction valid |
| loc_wr | input | 1 | Local transaction command, 1 = write |
| loc_addr | input | 32 | Local transaction address |
| glb_vld | input | 1 | Global bus transaction valid |
| glb_wr | input | 1 | Global transaction command, 1 = write |
| glb_addr | input | 32 | Global transaction address |
| glb_src | input | 2 | Cluster that issued the global transaction |
| fwd_glb_vld | output | 1 | Forward-to-global strobe |
| fwd_glb_wr | output | 1 | Command of the forwarded local transaction |
| fwd_glb_addr | output | 32 | Address of the forwarded local transaction |
| fwd_loc_vld | output | 1 | Forward-to-local strobe |
| fwd_loc_wr | output | 1 | Command of the forwarded global transaction |
| fwd_loc_addr | output | 32 | Address of the forwarded global transaction |

## Verification
The assertions check the rules that depend only on ports, on every cycle. Each strobe must follow a real snoop by one cycle with the same address and command. Global reads and self-sourced traffic must never reach the local bus. Remote-home local writes and local-home global writes must always cross. Whether a transaction crosses based on tag state needs a known history, so only the bench scenarios show it. These cover directory sharing and dirtying, fill and hit in the remote-line store, invalidation by remote writes, round-robin victim choice in a full set, and the ordering of same-cycle snoops.

// File: rtl/cf_pkg.sv
package cf_pkg;

    // State of a remote-home line held inside this cluster
    typedef enum logic [1:0] {
        RC_INV = 2'd0,
        RC_SHR = 2'd1,
        RC_DRT = 2'd2
    } rc_state_e;

    // State of a local-home line as seen held by other clusters
    typedef enum logic [1:0] {
        DIR_INV = 2'd0,
        DIR_SHR = 2'd1,
        DIR_DRT = 2'd2
    } dir_state_e;

endpackage

// File: rtl/cf_home_decode.sv
module cf_home_decode #(
    parameter int              HOME_W = 2,
    parameter logic [HOME_W-1:0] MY_ID = '0
) (
    input  logic [HOME_W-1:0] home_bits,
    output logic              is_local
);

    always_comb begin
        is_local = (home_bits == MY_ID);
    end

endmodule

// File: rtl/cf_remote_tags.sv
module cf_remote_tags
    import cf_pkg::*;
#(
    parameter int LINE_W = 27,
    parameter int SETS   = 16,
    parameter int WAYS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    // invalidation from a foreign global write
    input  logic              g_vld,
    input  logic [LINE_W-1:0] g_line,
    output logic              g_dirty_hit,
    // local access to a remote-home line
    input  logic              l_vld,
    input  logic              l_wr,
    input  logic [LINE_W-1:0] l_line,
    output logic              l_hit
);

    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W = LINE_W - IDX_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef struct packed {
        logic      [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        rc_state_e [SETS-1:0][WAYS-1:0]            st;
        logic      [SETS-1:0][WAY_W-1:0]           ptr;
    } rt_t;

    rt_t s_d, s_q;

    logic [IDX_W-1:0] g_idx, l_idx;
    logic [TAG_W-1:0] g_tag, l_tag;
    logic [WAY_W-1:0] hit_way_d, free_way_d, victim_d;
    logic             have_free_d;

    always_comb begin
        s_d         = s_q;
        g_idx       = g_line[IDX_W-1:0];
        g_tag       = g_line[LINE_W-1:IDX_W];
        l_idx       = l_line[IDX_W-1:0];
        l_tag       = l_line[LINE_W-1:IDX_W];
        g_dirty_hit = 1'b0;
        l_hit       = 1'b0;
        hit_way_d   = '0;
        free_way_d  = '0;
        have_free_d = 1'b0;
        victim_d    = '0;

        // global invalidation goes first
        for (int w = 0; w < WAYS; w++) begin
            if (g_vld && s_q.st[g_idx][w] != RC_INV && s_q.tag[g_idx][w] == g_tag) begin
                if (s_q.st[g_idx][w] == RC_DRT) begin
                    g_dirty_hit = 1'b1;
                end
                s_d.st[g_idx][w] = RC_INV;
            end
        end

        // local lookup sees the post-invalidation contents
        for (int w = 0; w < WAYS; w++) begin
            if (s_d.st[l_idx][w] != RC_INV && s_d.tag[l_idx][w] == l_tag) begin
                l_hit     = 1'b1;
                hit_way_d = WAY_W'(w);
            end
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (s_d.st[l_idx][w] == RC_INV) begin
                have_free_d = 1'b1;
                free_way_d  = WAY_W'(w);
            end
        end
        victim_d = have_free_d ? free_way_d : s_q.ptr[l_idx];

        if (l_vld) begin
            if (l_hit) begin
                if (l_wr) begin
                    s_d.st[l_idx][hit_way_d] = RC_DRT;
                end
            end else begin
                s_d.tag[l_idx][victim_d] = l_tag;
                s_d.st[l_idx][victim_d]  = l_wr ? RC_DRT : RC_SHR;
                if (!have_free_d) begin
                    s_d.ptr[l_idx] = (s_q.ptr[l_idx] == WAY_W'(WAYS - 1)) ? '0
                                   : s_q.ptr[l_idx] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/cf_home_dir.sv
module cf_home_dir
    import cf_pkg::*;
#(
    parameter int LINE_W  = 27,
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    // foreign global access to a local-home line
    input  logic              g_vld,
    input  logic              g_wr,
    input  logic [LINE_W-1:0] g_line,
    // local access to a local-home line
    input  logic              l_vld,
    input  logic              l_wr,
    input  logic [LINE_W-1:0] l_line,
    output logic              l_present,
    output logic              l_dirty
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int TAG_W = LINE_W - IDX_W;

    typedef struct packed {
        logic       [ENTRIES-1:0][TAG_W-1:0] tag;
        dir_state_e [ENTRIES-1:0]            st;
    } dir_t;

    dir_t s_d, s_q;

    logic [IDX_W-1:0] g_idx, l_idx;
    logic [TAG_W-1:0] g_tag, l_tag;

    always_comb begin
        s_d       = s_q;
        g_idx     = g_line[IDX_W-1:0];
        g_tag     = g_line[LINE_W-1:IDX_W];
        l_idx     = l_line[IDX_W-1:0];
        l_tag     = l_line[LINE_W-1:IDX_W];

        // foreign global access first: record the remote sharer or owner
        if (g_vld) begin
            s_d.tag[g_idx] = g_tag;
            s_d.st[g_idx]  = g_wr ? DIR_DRT : DIR_SHR;
        end

        l_present = (s_d.st[l_idx] != DIR_INV) && (s_d.tag[l_idx] == l_tag);
        l_dirty   = l_present && (s_d.st[l_idx] == DIR_DRT);

        if (l_vld && l_present) begin
            if (l_wr) begin
                s_d.st[l_idx] = DIR_INV;
            end else if (l_dirty) begin
                s_d.st[l_idx] = DIR_SHR;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/cf_cluster_filter.sv
module cf_cluster_filter
    import cf_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                HOME_W      = 2,
    parameter logic [HOME_W-1:0] MY_ID       = 2'd1,
    parameter int                OFF_W       = 5,
    parameter int                RC_SETS     = 16,
    parameter int                RC_WAYS     = 4,
    parameter int                DIR_ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_vld,
    input  logic              loc_wr,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic              glb_vld,
    input  logic              glb_wr,
    input  logic [ADDR_W-1:0] glb_addr,
    input  logic [HOME_W-1:0] glb_src,
    output logic              fwd_glb_vld,
    output logic              fwd_glb_wr,
    output logic [ADDR_W-1:0] fwd_glb_addr,
    output logic              fwd_loc_vld,
    output logic              fwd_loc_wr,
    output logic [ADDR_W-1:0] fwd_loc_addr
);

    localparam int LINE_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic              g_vld;
        logic              g_wr;
        logic [ADDR_W-1:0] g_addr;
        logic              l_vld;
        logic              l_wr;
        logic [ADDR_W-1:0] l_addr;
    } out_t;

    out_t o_d, o_q;

    logic loc_is_local, glb_is_local;
    logic g_act;
    logic rt_g_vld, rt_g_dirty_hit, rt_l_vld, rt_l_hit;
    logic dir_g_vld, dir_l_vld, dir_present, dir_dirty;
    logic fwd_g, fwd_l;

    cf_home_decode #(.HOME_W(HOME_W), .MY_ID(MY_ID)) u_dec_loc (
        .home_bits (loc_addr[ADDR_W-1 -: HOME_W]),
        .is_local  (loc_is_local)
    );

    cf_home_decode #(.HOME_W(HOME_W), .MY_ID(MY_ID)) u_dec_glb (
        .home_bits (glb_addr[ADDR_W-1 -: HOME_W]),
        .is_local  (glb_is_local)
    );

    always_comb begin
        g_act     = glb_vld && (glb_src != MY_ID);
        rt_g_vld  = g_act && glb_wr && !glb_is_local;
        dir_g_vld = g_act && glb_is_local;
        rt_l_vld  = loc_vld && !loc_is_local;
        dir_l_vld = loc_vld && loc_is_local;
    end

    cf_remote_tags #(.LINE_W(LINE_W), .SETS(RC_SETS), .WAYS(RC_WAYS)) u_rtags (
        .clk         (clk),
        .rst_n       (rst_n),
        .g_vld       (rt_g_vld),
        .g_line      (glb_addr[ADDR_W-1:OFF_W]),
        .g_dirty_hit (rt_g_dirty_hit),
        .l_vld       (rt_l_vld),
        .l_wr        (loc_wr),
        .l_line      (loc_addr[ADDR_W-1:OFF_W]),
        .l_hit       (rt_l_hit)
    );

    cf_home_dir #(.LINE_W(LINE_W), .ENTRIES(DIR_ENTRIES)) u_hdir (
        .clk       (clk),
        .rst_n     (rst_n),
        .g_vld     (dir_g_vld),
        .g_wr      (glb_wr),
        .g_line    (glb_addr[ADDR_W-1:OFF_W]),
        .l_vld     (dir_l_vld),
        .l_wr      (loc_wr),
        .l_line    (loc_addr[ADDR_W-1:OFF_W]),
        .l_present (dir_present),
        .l_dirty   (dir_dirty)
    );

    always_comb begin
        o_d = o_q;

        if (loc_wr) begin
            fwd_g = loc_vld && (!loc_is_local || dir_present);
        end else begin
            fwd_g = loc_vld && (loc_is_local ? dir_dirty : !rt_l_hit);
        end
        fwd_l = g_act && glb_wr && (glb_is_local || rt_g_dirty_hit);

        o_d.g_vld = fwd_g;
        o_d.l_vld = fwd_l;
        if (fwd_g) begin
            o_d.g_wr   = loc_wr;
            o_d.g_addr = loc_addr;
        end
        if (fwd_l) begin
            o_d.l_wr   = glb_wr;
            o_d.l_addr = glb_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign fwd_glb_vld  = o_q.g_vld;
    assign fwd_glb_wr   = o_q.g_wr;
    assign fwd_glb_addr = o_q.g_addr;
    assign fwd_loc_vld  = o_q.l_vld;
    assign fwd_loc_wr   = o_q.l_wr;
    assign fwd_loc_addr = o_q.l_addr;

endmodule

// File: rtl/cf_cluster_filter_chk.sv
module cf_cluster_filter_chk #(
    parameter int                ADDR_W = 32,
    parameter int                HOME_W = 2,
    parameter logic [HOME_W-1:0] MY_ID  = 2'd1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              loc_vld,
    input logic              loc_wr,
    input logic [ADDR_W-1:0] loc_addr,
    input logic              glb_vld,
    input logic              glb_wr,
    input logic [ADDR_W-1:0] glb_addr,
    input logic [HOME_W-1:0] glb_src,
    input logic              fwd_glb_vld,
    input logic              fwd_glb_wr,
    input logic [ADDR_W-1:0] fwd_glb_addr,
    input logic              fwd_loc_vld,
    input logic              fwd_loc_wr,
    input logic [ADDR_W-1:0] fwd_loc_addr
);

    p_glb_fwd_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_glb_vld |-> ($past(loc_vld) && fwd_glb_wr == $past(loc_wr)
                         && fwd_glb_addr == $past(loc_addr)));

    p_loc_fwd_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_loc_vld |-> ($past(glb_vld) && $past(glb_src) != MY_ID
                         && fwd_loc_addr == $past(glb_addr)));

    p_glb_read_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_loc_vld |-> fwd_loc_wr);

    p_self_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_vld && glb_src == MY_ID) |=> !fwd_loc_vld);

    p_remote_write_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_vld && loc_wr && loc_addr[ADDR_W-1 -: HOME_W] != MY_ID) |=> fwd_glb_vld);

    p_home_write_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_vld && glb_wr && glb_src != MY_ID && glb_addr[ADDR_W-1 -: HOME_W] == MY_ID)
        |=> fwd_loc_vld);

endmodule

bind cf_cluster_filter cf_cluster_filter_chk #(
    .ADDR_W (ADDR_W),
    .HOME_W (HOME_W),
    .MY_ID  (MY_ID)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .loc_vld      (loc_vld),
    .loc_wr       (loc_wr),
    .loc_addr     (loc_addr),
    .glb_vld      (glb_vld),
    .glb_wr       (glb_wr),
    .glb_addr     (glb_addr),
    .glb_src      (glb_src),
    .fwd_glb_vld  (fwd_glb_vld),
    .fwd_glb_wr   (fwd_glb_wr),
    .fwd_glb_addr (fwd_glb_addr),
    .fwd_loc_vld  (fwd_loc_vld),
    .fwd_loc_wr   (fwd_loc_wr),
    .fwd_loc_addr (fwd_loc_addr)
);

// File: tb/cf_cluster_filter_tb_top.sv
module cf_cluster_filter_tb_top;

    localparam int         CLK_PERIOD = 10;
    localparam logic [1:0] ME         = 2'd1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        loc_vld = 1'b0, loc_wr = 1'b0;
    logic [31:0] loc_addr = '0;
    logic        glb_vld = 1'b0, glb_wr = 1'b0;
    logic [31:0] glb_addr = '0;
    logic [1:0]  glb_src = '0;
    logic        fwd_glb_vld, fwd_glb_wr, fwd_loc_vld, fwd_loc_wr;
    logic [31:0] fwd_glb_addr, fwd_loc_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cf_cluster_filter #(.MY_ID(ME)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .loc_vld(loc_vld), .loc_wr(loc_wr), .loc_addr(loc_addr),
        .glb_vld(glb_vld), .glb_wr(glb_wr), .glb_addr(glb_addr), .glb_src(glb_src),
        .fwd_glb_vld(fwd_glb_vld), .fwd_glb_wr(fwd_glb_wr), .fwd_glb_addr(fwd_glb_addr),
        .fwd_loc_vld(fwd_loc_vld), .fwd_loc_wr(fwd_loc_wr), .fwd_loc_addr(fwd_loc_addr)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one snoop cycle on either or both buses, then sample the registered result
    task automatic snoop(input logic lv, input logic lw, input logic [31:0] la,
                         input logic gv, input logic gw, input logic [31:0] ga,
                         input logic [1:0] gs);
        @(negedge clk);
        loc_vld = lv; loc_wr = lw; loc_addr = la;
        glb_vld = gv; glb_wr = gw; glb_addr = ga; glb_src = gs;
        @(negedge clk);
        loc_vld = 1'b0; glb_vld = 1'b0;
    endtask

    task automatic loc_op(input logic wr, input logic [31:0] a);
        snoop(1'b1, wr, a, 1'b0, 1'b0, 32'h0, 2'd0);
    endtask

    task automatic glb_op(input logic wr, input logic [31:0] a, input logic [1:0] src);
        snoop(1'b0, 1'b0, 32'h0, 1'b1, wr, a, src);
    endtask

    task automatic expect_glb(input string req, input logic v, input logic wr, input logic [31:0] a);
        check(req, "fwd_glb_vld", 32'(fwd_glb_vld), 32'(v));
        if (v) begin
            check(req, "fwd_glb_wr", 32'(fwd_glb_wr), 32'(wr));
            check(req, "fwd_glb_addr", fwd_glb_addr, a);
        end
    endtask

    task automatic expect_loc(input string req, input logic v, input logic [31:0] a);
        check(req, "fwd_loc_vld", 32'(fwd_loc_vld), 32'(v));
        if (v) begin
            check(req, "fwd_loc_wr", 32'(fwd_loc_wr), 32'd1);
            check(req, "fwd_loc_addr", fwd_loc_addr, a);
        end
    endtask

    function automatic logic [31:0] set_a_addr(input int t);
        return {2'b10, 21'(t), 4'hA, 5'h0};
    endfunction

    task automatic t_reset();
        check("R1", "fwd_glb_vld after reset", 32'(fwd_glb_vld), 32'd0);
        check("R1", "fwd_loc_vld after reset", 32'(fwd_loc_vld), 32'd0);
        loc_op(1'b0, 32'h8000_0C20);      // empty store: remote read misses
        expect_glb("R1", 1'b1, 1'b0, 32'h8000_0C20);
    endtask

    task automatic t_decode_and_write();
        loc_op(1'b1, 32'h8000_0040);      // remote home, write
        expect_glb("R3", 1'b1, 1'b1, 32'h8000_0040);
        loc_op(1'b1, 32'hC000_0060);      // [31:30]=11, remote home
        expect_glb("R2", 1'b1, 1'b1, 32'hC000_0060);
        loc_op(1'b1, 32'h4000_0100);      // [31:30]=01, local home, unshared
        expect_glb("R2", 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_home_sharing();
        glb_op(1'b0, 32'h4000_0100, 2'd2);
        expect_loc("R6", 1'b0, 32'h0);    // global read not passed down
        loc_op(1'b1, 32'h4000_0100);
        expect_glb("R10", 1'b1, 1'b1, 32'h4000_0100);
        loc_op(1'b1, 32'h4000_0100);      // remote copies gone
        expect_glb("R3", 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_home_dirty();
        loc_op(1'b0, 32'h4000_0200);
        expect_glb("R4", 1'b0, 1'b0, 32'h0);
        glb_op(1'b1, 32'h4000_0200, 2'd2);
        expect_loc("R5", 1'b1, 32'h4000_0200);
        loc_op(1'b0, 32'h4000_0200);
        expect_glb("R10", 1'b1, 1'b0, 32'h4000_0200);
        loc_op(1'b0, 32'h4000_0200);      // now shared-remote
        expect_glb("R4", 1'b0, 1'b0, 32'h0);
        loc_op(1'b1, 32'h4000_0200);      // shared still forces a write out
        expect_glb("R3", 1'b1, 1'b1, 32'h4000_0200);
    endtask

    task automatic t_remote_cache();
        loc_op(1'b0, 32'h8000_0300);
        expect_glb("R4", 1'b1, 1'b0, 32'h8000_0300);
        loc_op(1'b0, 32'h8000_0300);
        expect_glb("R8", 1'b0, 1'b0, 32'h0);
        glb_op(1'b1, 32'h8000_0300, 2'd2);  // shared here: no pass down
        expect_loc("R5", 1'b0, 32'h0);
        loc_op(1'b0, 32'h8000_0300);
        expect_glb("R9", 1'b1, 1'b0, 32'h8000_0300);
        loc_op(1'b1, 32'h8000_0300);
        expect_glb("R3", 1'b1, 1'b1, 32'h8000_0300);
        glb_op(1'b1, 32'h8000_0300, 2'd3);  // dirty here: pass down
        expect_loc("R5", 1'b1, 32'h8000_0300);
        loc_op(1'b0, 32'h8000_0300);
        expect_glb("R9", 1'b1, 1'b0, 32'h8000_0300);
    endtask

    task automatic t_self_ignored();
        glb_op(1'b1, 32'h4000_0400, ME);
        expect_loc("R6", 1'b0, 32'h0);
        loc_op(1'b1, 32'h4000_0400);      // directory untouched
        expect_glb("R6", 1'b0, 1'b0, 32'h0);
        loc_op(1'b0, 32'h8000_0500);
        expect_glb("R6", 1'b1, 1'b0, 32'h8000_0500);
        glb_op(1'b1, 32'h8000_0500, ME);  // own write must not invalidate
        loc_op(1'b0, 32'h8000_0500);
        expect_glb("R6", 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_replacement();
        for (int t = 0; t < 4; t++) begin
            loc_op(1'b0, set_a_addr(t));
            expect_glb("R8", 1'b1, 1'b0, set_a_addr(t));
        end
        for (int t = 0; t < 4; t++) begin
            loc_op(1'b0, set_a_addr(t));
            expect_glb("R8", 1'b0, 1'b0, 32'h0);
        end
        loc_op(1'b0, set_a_addr(4));      // evicts way 0 (tag 0)
        expect_glb("R8", 1'b1, 1'b0, set_a_addr(4));
        loc_op(1'b0, set_a_addr(1));
        expect_glb("R8", 1'b0, 1'b0, 32'h0);
        loc_op(1'b0, set_a_addr(0));      // miss, evicts way 1 (tag 1)
        expect_glb("R8", 1'b1, 1'b0, set_a_addr(0));
        loc_op(1'b0, set_a_addr(1));
        expect_glb("R8", 1'b1, 1'b0, set_a_addr(1));
    endtask

    task automatic t_same_cycle();
        loc_op(1'b0, 32'h8000_0800);
        expect_glb("R11", 1'b1, 1'b0, 32'h8000_0800);
        snoop(1'b1, 1'b0, 32'h8000_0800, 1'b1, 1'b1, 32'h8000_0800, 2'd2);
        expect_glb("R11", 1'b1, 1'b0, 32'h8000_0800);
        expect_loc("R11", 1'b0, 32'h0);
        snoop(1'b1, 1'b1, 32'h4000_0900, 1'b1, 1'b0, 32'h4000_0900, 2'd3);
        expect_glb("R11", 1'b1, 1'b1, 32'h4000_0900);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode_and_write();
        t_home_sharing();
        t_home_dirty();
        t_remote_cache();
        t_self_ignored();
        t_replacement();
        t_same_cycle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule